// File: doc/BRIEF.md
# Multichannel grayscale PWM generator

This block turns sixteen per-channel brightness levels into sixteen pulse-width-modulated outputs. A single counter, driven by the grayscale reference clock, runs through a period of either 4096 or 65536 steps. Each channel holds its output high for as many steps of that period as its level requests. All inputs are synchronous to the same grayscale clock.

Levels are double-buffered. Writes go into a pending store of sixteen 16-bit entries, and the compare logic cannot see them there. A one-cycle latch strobe arms a transfer of the whole pending store into the active compare registers. The transfer happens on the last step of the current period, so every period is produced from one consistent set of levels. Two optional features shape the outputs further. Per-channel enables force individual outputs low. A stagger option delays each channel by its index modulo 4, counted in clock cycles, so the edges of the sixteen outputs do not all switch in the same cycle.

Top module: `gs_pwm_array`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears the counter, the pending store, the active levels, the stagger delay stages and all outputs; `pwm_out` is 0 in the cycle after such an edge.
- R2: With stagger off, `pwm_out[i]` after a rising edge equals (`ch_en[i]` and counter < active level of channel i), both sampled at that edge. A level of 0 keeps the output low for the whole period, and when the counter is at its top value every output is low after the edge.
- R3: When `wide_mode` is 0, the counter returns to 0 after its low 12 bits reach 4095, and only the low 12 bits of each level take part in the compare, so a level of 0x1000 acts as 0 and 0xFFFF acts as 4095.
- R4: When `wide_mode` is 1, the counter runs 0 to 65535 and then returns to 0, and all 16 bits of each level take part in the compare.
- R5: A write (`wr_en`=1) stores `wr_data` into pending entry `wr_addr` and does not change any output until a later latch takes effect.
- R6: A `latch_req` pulse in any cycle copies the entire pending store into the active levels at the last step of the current period. The new levels govern the compare from counter value 0 of the next period. A write made on that same last step is not part of the copy.
- R7: With `stagger_en`=1, output i is the stagger-off result delayed by (i mod 4) additional clock cycles. Channels 0, 4, 8 and 12 are not delayed, and channel 3 lags by three cycles.
- R8: With `ch_en[i]`=0 at an edge and stagger off, `pwm_out[i]` is 0 after that edge.
- R9: Outside the wrap point, the counter advances by exactly one on every grayscale clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Grayscale reference clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the pending store |
| wr_addr | input | 4 | Channel index of the write |
| wr_data | input | 16 | Grayscale level to store |
| latch_req | input | 1 | Arms a pending-to-active transfer at the next wrap |
| wide_mode | input | 1 | 1 selects a 16-bit period, 0 a 12-bit period |
| stagger_en | input | 1 | Enables the index-mod-4 output delay |
| ch_en | input | 16 | Per-channel enable, active high |
| pwm_out | output | 16 | PWM outputs, one per channel |

## Verification
The properties assume that every input is sampled only at rising edges of the grayscale clock. They also assume that `wr_addr` always names an existing channel. The period and step properties are stated against whichever width mode is present in that cycle, so a mode switch in the middle of a period does not break them. The stimulus changes inputs only at falling edges and writes only to addresses 0 to 15. It switches mode and stagger mid-run, which covers both the steady state and the transitions. The reference model in the bench then reproduces the outcome of every such switch cycle by cycle.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;

    // Channel count, level width and narrow-period width
    localparam int GS_CH     = 16;
    localparam int GS_W      = 16;
    localparam int GS_NARROW = 12;
    // Number of stagger groups (channel index modulo this value)
    localparam int GS_GROUPS = 4;

    typedef logic [GS_W-1:0] gs_level_t;

endpackage

// File: rtl/gs_pend_buf.sv
// Pending level store: written one entry at a time, read in full by the
// active registers when a transfer happens.
module gs_pend_buf #(
    parameter int NCH = 16,
    parameter int GW  = 16,
    parameter int AW  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [GW-1:0]            wr_data,
    output logic [NCH-1:0][GW-1:0]   pend
);

    typedef struct packed {
        logic [NCH-1:0][GW-1:0] mem;
    } pend_st_t;

    pend_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_addr) < NCH)) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.mem;

endmodule

// File: rtl/gs_period_ctr.sv
// Shared period counter with 12/16-bit wrap and latch arming.
module gs_period_ctr #(
    parameter int GW = 16,
    parameter int NW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wide_mode,
    input  logic          latch_req,
    output logic [GW-1:0] cnt,
    output logic          load
);

    typedef struct packed {
        logic [GW-1:0] cnt;
        logic          armed;
    } ctr_st_t;

    ctr_st_t st_d, st_q;
    logic    lo_full;
    logic    hi_full;
    logic    wrap;

    always_comb begin
        lo_full = &st_q.cnt[NW-1:0];
        hi_full = &st_q.cnt[GW-1:NW];
        // Narrow mode wraps on the low bits alone; wide mode needs all ones
        wrap    = lo_full && (!wide_mode || hi_full);
        // A request in the wrap cycle itself is honoured immediately
        load    = wrap && (st_q.armed || latch_req);

        st_d = st_q;
        if (wrap) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b0;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.armed = st_q.armed || latch_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/gs_active_regs.sv
// Active compare levels, replaced as a whole on a transfer.
module gs_active_regs #(
    parameter int NCH = 16,
    parameter int GW  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [NCH-1:0][GW-1:0]   pend,
    output logic [NCH-1:0][GW-1:0]   act
);

    typedef struct packed {
        logic [NCH-1:0][GW-1:0] lvl;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.lvl = pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.lvl;

endmodule

// File: rtl/gs_chan_slice.sv
// One channel: mode-masked compare, optional GRP-cycle delay, output flop.
module gs_chan_slice #(
    parameter int GW  = 16,
    parameter int NW  = 12,
    parameter int GRP = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [GW-1:0] cnt,
    input  logic          wide_mode,
    input  logic [GW-1:0] level,
    input  logic          en,
    input  logic          stagger_en,
    output logic          pwm
);

    localparam logic [GW-1:0] NMASK = {{(GW-NW){1'b0}}, {NW{1'b1}}};

    typedef struct packed {
        logic pwm;
    } sl_st_t;

    sl_st_t        st_d, st_q;
    logic [GW-1:0] eff;
    logic          raw;
    logic          tap;

    always_comb begin
        eff = wide_mode ? level : (level & NMASK);
        raw = en && (cnt < eff);
    end

    generate
        if (GRP == 0) begin : g_nodly
            assign tap = raw;
        end else begin : g_dly
            logic [GRP-1:0] dly_d, dly_q;
            if (GRP == 1) begin : g_one
                always_comb dly_d = raw;
            end else begin : g_many
                always_comb dly_d = {dly_q[GRP-2:0], raw};
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    dly_q <= '0;
                end else begin
                    dly_q <= dly_d;
                end
            end
            assign tap = dly_q[GRP-1];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.pwm = stagger_en ? tap : raw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm = st_q.pwm;

endmodule

// File: rtl/gs_pwm_array.sv
// Top: pending store, period counter, active levels and channel slices.
module gs_pwm_array
    import gs_pwm_pkg::*;
#(
    parameter int NCH  = GS_CH,
    parameter int GW   = GS_W,
    parameter int NW   = GS_NARROW,
    parameter int NGRP = GS_GROUPS,
    parameter int AW   = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [GW-1:0]   wr_data,
    input  logic            latch_req,
    input  logic            wide_mode,
    input  logic            stagger_en,
    input  logic [NCH-1:0]  ch_en,
    output logic [NCH-1:0]  pwm_out
);

    logic [NCH-1:0][GW-1:0] pend;
    logic [NCH-1:0][GW-1:0] act;
    logic [GW-1:0]          cnt;
    logic                   load;

    gs_pend_buf #(.NCH(NCH), .GW(GW), .AW(AW)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pend    (pend)
    );

    gs_period_ctr #(.GW(GW), .NW(NW)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .wide_mode (wide_mode),
        .latch_req (latch_req),
        .cnt       (cnt),
        .load      (load)
    );

    gs_active_regs #(.NCH(NCH), .GW(GW)) u_act (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .pend (pend),
        .act  (act)
    );

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            gs_chan_slice #(.GW(GW), .NW(NW), .GRP(i % NGRP)) u_slice (
                .clk        (clk),
                .rst        (rst),
                .cnt        (cnt),
                .wide_mode  (wide_mode),
                .level      (act[i]),
                .en         (ch_en[i]),
                .stagger_en (stagger_en),
                .pwm        (pwm_out[i])
            );
        end
    endgenerate

endmodule

// File: rtl/gs_pwm_array_chk.sv
// Properties for gs_pwm_array, attached with bind.
module gs_pwm_array_chk #(
    parameter int NCH = 16,
    parameter int GW  = 16,
    parameter int NW  = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            wide_mode,
    input logic            stagger_en,
    input logic [NCH-1:0]  ch_en,
    input logic [NCH-1:0]  pwm_out,
    input logic [GW-1:0]   cnt
);

    localparam logic [NW-1:0] LO_TOP = '1;
    localparam logic [GW-1:0] TOP    = '1;

    // R1: a reset edge leaves every output low
    assert_rst_quiet_R1: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

    // R2: nothing is lit right after the top step of a wide period
    assert_top_dark_R2: assert property (@(posedge clk) disable iff (rst)
        (!stagger_en && wide_mode && cnt == TOP) |=> (pwm_out == '0));

    // R3: narrow period wraps after 4095
    assert_narrow_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (!wide_mode && cnt[NW-1:0] == LO_TOP) |=> (cnt == '0));

    // R4: wide period wraps after 65535
    assert_wide_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && cnt == TOP) |=> (cnt == '0));

    // R9: single step away from the wrap point
    assert_single_step_R9: assert property (@(posedge clk) disable iff (rst)
        (wide_mode ? (cnt != TOP) : (cnt[NW-1:0] != LO_TOP))
        |=> (cnt == $past(cnt) + 1'b1));

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_en
            // R8: a disabled channel stays low
            assert_off_R8: assert property (@(posedge clk) disable iff (rst)
                (!stagger_en && !ch_en[i]) |=> !pwm_out[i]);
        end
    endgenerate

endmodule

bind gs_pwm_array gs_pwm_array_chk #(.NCH(NCH), .GW(GW), .NW(NW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wide_mode  (wide_mode),
    .stagger_en (stagger_en),
    .ch_en      (ch_en),
    .pwm_out    (pwm_out),
    .cnt        (cnt)
);

// File: tb/sim_gs_pwm_array.sv
`timescale 1ns/1ps
module sim_gs_pwm_array;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        latch_req = 1'b0;
    logic        wide_mode = 1'b0;
    logic        stagger_en = 1'b0;
    logic [15:0] ch_en = '1;
    logic [15:0] pwm_out;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_req = "R1";

    // Scoreboard queues
    bit [15:0] exp_q[$];
    string     tag_q[$];

    // Reference model state (value after each rising edge)
    bit [15:0] m_cnt;
    bit [15:0] m_act  [16];
    bit [15:0] m_pend [16];
    bit        m_armed;
    bit [15:0] m_d1, m_d2, m_d3, m_out;

    always #2.5 clk = ~clk;

    gs_pwm_array u0 (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .latch_req  (latch_req),
        .wide_mode  (wide_mode),
        .stagger_en (stagger_en),
        .ch_en      (ch_en),
        .pwm_out    (pwm_out)
    );

    task automatic model_edge();
        bit [15:0] raw;
        bit        wrapv;
        if (rst) begin
            m_cnt = '0; m_armed = 1'b0;
            m_d1 = '0; m_d2 = '0; m_d3 = '0; m_out = '0;
            for (int i = 0; i < 16; i++) begin
                m_act[i] = '0; m_pend[i] = '0;
            end
        end else begin
            for (int i = 0; i < 16; i++) begin
                bit [15:0] v;
                v = wide_mode ? m_act[i] : (m_act[i] & 16'h0FFF);
                raw[i] = ch_en[i] && (m_cnt < v);
            end
            for (int i = 0; i < 16; i++) begin
                bit t;
                case (i % 4)
                    0: t = raw[i];
                    1: t = m_d1[i];
                    2: t = m_d2[i];
                    default: t = m_d3[i];
                endcase
                m_out[i] = stagger_en ? t : raw[i];
            end
            m_d3 = m_d2; m_d2 = m_d1; m_d1 = raw;
            wrapv = wide_mode ? (m_cnt == 16'hFFFF) : (m_cnt[11:0] == 12'hFFF);
            if (wrapv && (m_armed || latch_req)) begin
                for (int i = 0; i < 16; i++) m_act[i] = m_pend[i];
            end
            m_armed = wrapv ? 1'b0 : (m_armed || latch_req);
            m_cnt   = wrapv ? 16'h0 : m_cnt + 16'h1;
            if (wr_en) m_pend[wr_addr] = wr_data;
        end
    endtask

    // Driver: one clock cycle, expected output pushed to the scoreboard
    task automatic step();
        @(posedge clk);
        model_edge();
        exp_q.push_back(m_out);
        tag_q.push_back(cur_req);
        @(negedge clk);
    endtask

    task automatic write_lvl(input int ch, input bit [15:0] val);
        wr_en = 1'b1; wr_addr = 4'(ch); wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_latch();
        latch_req = 1'b1;
        step();
        latch_req = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: pop and compare at falling edges
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit [15:0] e;
            string     t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (pwm_out !== e) begin
                n_bad++;
                $display("FAIL %s: pwm_out=%h expected %h at %0t", t, pwm_out, e, $time);
            end
        end
    end

    // Watchdog
    initial begin
        #(190000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        summary();
    end

    initial begin
        // R1: reset with all channels enabled
        cur_req = "R1";
        repeat (3) step();
        rst = 1'b0;
        repeat (20) step();
        n_chk++;
        if (pwm_out !== 16'h0) begin
            n_bad++;
            $display("FAIL R1: pwm_out=%h expected %h", pwm_out, 16'h0);
        end

        // R5: pending writes stay invisible across a wrap
        cur_req = "R5";
        write_lvl(0, 16'h0000);
        write_lvl(1, 16'h0001);
        write_lvl(2, 16'h0002);
        write_lvl(3, 16'h0FFF);
        write_lvl(4, 16'h1000);
        write_lvl(5, 16'hFFFF);
        write_lvl(6, 16'd100);
        for (int i = 7; i < 16; i++) write_lvl(i, 16'(i * 333));
        repeat (5000) step();

        // R6: latch mid-period applies at next wrap
        cur_req = "R6";
        pulse_latch();
        write_lvl(6, 16'd2000); // stays pending: no second latch
        repeat (4200) step();

        // R2 / R3: steady narrow period with boundary levels
        cur_req = "R2";
        repeat (2048) step();
        cur_req = "R3";
        repeat (4096) step();

        // R8: enable pattern
        cur_req = "R8";
        ch_en = 16'hA5A5;
        repeat (4096) step();
        ch_en = 16'hFFFF;

        // R7: stagger on
        cur_req = "R7";
        stagger_en = 1'b1;
        repeat (4200) step();
        stagger_en = 1'b0;

        // R4: wide period with new levels
        cur_req = "R4";
        wide_mode = 1'b1;
        write_lvl(0, 16'h8000);
        write_lvl(1, 16'hFFFF);
        write_lvl(2, 16'h1001);
        write_lvl(3, 16'h0001);
        pulse_latch();
        repeat (70000) step();

        // R9: back to narrow mid-period; stepping continues
        cur_req = "R9";
        wide_mode = 1'b0;
        repeat (5000) step();

        #1;
        summary();
    end

endmodule